// File: doc/BRIEF.md
# Performance Monitor Box Controller

This block is the box-level performance monitor for one link. It holds a set of generic event counters, each with its own 32-bit control word, plus one box-wide control word. All of them sit behind a simple 32-bit configuration register port addressed by byte offset. Each counter adds one on every cycle in which its event input is high, its enable bit is set, and the box is not frozen.

The box control word is write-only and decides how freezing works. A freeze-enable bit qualifies two freeze sources: the external freeze input and a manual freeze bit. With freeze-enable clear, neither source has any effect. The same word carries two self-clearing action bits. One zeroes every counter and the other zeroes every control word, each in a single write.

Counters are 48 bits wide. Each is read as two 32-bit words: the low word holds bits 31:0 and the high word holds the remaining bits, padded with zeros. Writes take effect at the clock edge that samples them. A new freeze or enable setting therefore governs counting from the next cycle onwards.

Top module: `pmon_box`

## Requirements
- R1: After reset, all counters and all control words read 0, and freezing is disabled.
- R2: The control words of counters 0, 1 and 2 sit at offsets 0xD8, 0xDC and 0xE0. Each stores and reads back the full 32-bit written value. Bit 0 is the counter enable.
- R3: A counter increments by exactly one at each clock edge where its event input is high, its enable bit is 1 and the box is not frozen. Otherwise it holds its value.
- R4: Counter i is read at offset 0xA0+8*i, which returns bits 31:0. Offset 0xA4+8*i returns bits 47:32 in bits 15:0, with bits 31:16 reading 0.
- R5: The box control word sits at offset 0xF4. Bit 16 is freeze-enable and bit 8 is manual freeze; both are loaded by every write. The word always reads 0.
- R6: With freeze-enable = 1, a high freeze input stops every counter in the cycles where it is high. With freeze-enable = 0, the freeze input is ignored.
- R7: Manual freeze (bit 8) stops every counter only while freeze-enable (bit 16) is also 1.
- R8: Writing 0xF4 with bit 1 set zeroes all counters at that edge. This takes priority over an event in the same cycle.
- R9: Writing 0xF4 with bit 0 set zeroes all control words at that edge, leaving the counters unchanged.
- R10: A counter at its all-ones value wraps to 0 on the next counted event.
- R11: Writes to counter offsets or unmapped offsets change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | External freeze request |
| event_i | input | NUM_CTR | Per-counter event strobes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration byte offset |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| cfg_rdata_o | output | DATA_W | Read data for cfg_addr_i (combinational) |

## Verification
The assertions check the following on every cycle:
- Each counter's step, hold-under-freeze and clear-priority behaviour.
- The clearing of control words.
- That a write to the box word disables or forces freezing from the next cycle.
- That the box word always reads zero.

The following are shown only by the bench scenarios:
- The address map of the split counter reads.
- That writes to counter and unmapped offsets are ignored.
- That the freeze input is ignored while freeze-enable is clear.
- Wrap-around, which the bench shows on a narrow counter instance.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int BOX_CTL_OFS  = 'hF4;
  localparam int CTL_BASE     = 'hD8;
  localparam int CTL_STRIDE   = 4;
  localparam int CTR_BASE     = 'hA0;
  localparam int CTR_STRIDE   = 8;
  localparam int HI_WORD_OFS  = 4;

  localparam int FRZ_EN_BIT   = 16;
  localparam int FRZ_BIT      = 8;
  localparam int CLR_CTR_BIT  = 1;
  localparam int CLR_CTL_BIT  = 0;
  localparam int CTL_EN_BIT   = 0;

  typedef struct packed {
    logic frz_en;
    logic frz;
    logic clr_ctr;
    logic clr_ctl;
  } box_wr_t;
endpackage

// File: rtl/pmon_box_ctl.sv
module pmon_box_ctl
  import pmon_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sel_i,
  input  box_wr_t wr_i,
  input  logic    freeze_i,
  output logic    frozen_o,
  output logic    clr_ctr_o,
  output logic    clr_ctl_o
);
  logic frz_en_q, frz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_en_q <= 1'b0;
      frz_q    <= 1'b0;
    end else if (sel_i) begin
      frz_en_q <= wr_i.frz_en;
      frz_q    <= wr_i.frz;
    end
  end

  // freeze enable qualifies both sources
  assign frozen_o  = frz_en_q & (freeze_i | frz_q);
  // one-shot actions, never stored
  assign clr_ctr_o = sel_i & wr_i.clr_ctr;
  assign clr_ctl_o = sel_i & wr_i.clr_ctl;

  // R6
  frz_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i.frz_en) |=> !frozen_o);
  // R7
  frz_manual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i.frz_en && wr_i.frz) |=> frozen_o);
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
  import pmon_pkg::*;
#(
  parameter int CTR_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_ctl_i,
  input  logic              clr_ctr_i,
  input  logic              frozen_i,
  input  logic              event_i,
  output logic [DATA_W-1:0] ctl_o,
  output logic [CTR_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] ctl_q;
  logic [CTR_W-1:0]  cnt_q;
  logic              inc;

  assign inc = event_i & ctl_q[CTL_EN_BIT] & ~frozen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctl_q <= '0;
    else if (clr_ctl_i) ctl_q <= '0;
    else if (ctl_we_i)  ctl_q <= wdata_i;
  end

  // clear beats event; natural wrap at all-ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_ctr_i) cnt_q <= '0;
    else if (inc)       cnt_q <= cnt_q + 1'b1;
  end

  assign ctl_o = ctl_q;
  assign cnt_o = cnt_q;

  // R8
  ctr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ctr_i |=> (cnt_o == '0));
  // R6
  ctr_freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !clr_ctr_i) |=> $stable(cnt_o));
  // R3
  ctr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ctr_i && event_i && ctl_o[CTL_EN_BIT] && !frozen_i)
      |=> (cnt_o == CTR_W'($past(cnt_o) + 1'b1)));
  // R3
  ctr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ctr_i && !event_i) |=> $stable(cnt_o));
  // R9
  ctl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ctl_i |=> (ctl_o == '0));
endmodule

// File: rtl/pmon_rd_mux.sv
module pmon_rd_mux
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_CTR-1:0][DATA_W-1:0]  ctl_i,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]               rdata_o
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [NUM_CTR-1:0][WIDE_W-1:0] ext;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ext
    assign ext[g] = WIDE_W'(cnt_i[g]);
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr_i == ADDR_W'(CTL_BASE + CTL_STRIDE * i))
        rdata_o = ctl_i[i];
      if (addr_i == ADDR_W'(CTR_BASE + CTR_STRIDE * i))
        rdata_o = ext[i][DATA_W-1:0];
      if (addr_i == ADDR_W'(CTR_BASE + CTR_STRIDE * i + HI_WORD_OFS))
        rdata_o = ext[i][WIDE_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/pmon_box.sv
module pmon_box
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 3,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               freeze_i,
  input  logic [NUM_CTR-1:0] event_i,
  input  logic               cfg_wr_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  output logic [DATA_W-1:0]  cfg_rdata_o
);
  localparam logic [ADDR_W-1:0] BOX_ADDR = ADDR_W'(BOX_CTL_OFS);

  logic                             box_sel;
  box_wr_t                          box_wr;
  logic                             frozen, clr_ctr, clr_ctl;
  logic [NUM_CTR-1:0]               ctl_we;
  logic [NUM_CTR-1:0][DATA_W-1:0]   ctl;
  logic [NUM_CTR-1:0][CTR_W-1:0]    cnt;

  assign box_sel        = cfg_wr_i & (cfg_addr_i == BOX_ADDR);
  assign box_wr.frz_en  = cfg_wdata_i[FRZ_EN_BIT];
  assign box_wr.frz     = cfg_wdata_i[FRZ_BIT];
  assign box_wr.clr_ctr = cfg_wdata_i[CLR_CTR_BIT];
  assign box_wr.clr_ctl = cfg_wdata_i[CLR_CTL_BIT];

  pmon_box_ctl u_box_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (box_sel),
    .wr_i      (box_wr),
    .freeze_i  (freeze_i),
    .frozen_o  (frozen),
    .clr_ctr_o (clr_ctr),
    .clr_ctl_o (clr_ctl)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    assign ctl_we[g] = cfg_wr_i & (cfg_addr_i == ADDR_W'(CTL_BASE + CTL_STRIDE * g));

    pmon_counter #(
      .CTR_W  (CTR_W),
      .DATA_W (DATA_W)
    ) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (ctl_we[g]),
      .wdata_i   (cfg_wdata_i),
      .clr_ctl_i (clr_ctl),
      .clr_ctr_i (clr_ctr),
      .frozen_i  (frozen),
      .event_i   (event_i[g]),
      .ctl_o     (ctl[g]),
      .cnt_o     (cnt[g])
    );
  end

  pmon_rd_mux #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_rd_mux (
    .addr_i  (cfg_addr_i),
    .ctl_i   (ctl),
    .cnt_i   (cnt),
    .rdata_o (cfg_rdata_o)
  );

  // R5
  box_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == BOX_ADDR) |-> (cfg_rdata_o == '0));
endmodule

// File: tb/pmon_box_test.sv
module pmon_box_test;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freeze = 1'b0;
  logic [2:0]  ev = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  logic [2:0]  w_ev = '0;
  logic        w_wr = 1'b0;
  logic [7:0]  w_addr = '0;
  logic [31:0] w_wdata = '0;
  logic [31:0] w_rdata;

  int tests = 0;
  int fails = 0;

  logic [47:0] m_cnt [N];
  logic [31:0] m_ctl [N];
  bit          m_fen, m_frz;

  always #4 clk = ~clk;

  pmon_box uut (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(freeze), .event_i(ev),
    .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
  );

  pmon_box #(.CTR_W(12)) uut_wrap (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(1'b0), .event_i(w_ev),
    .cfg_wr_i(w_wr), .cfg_addr_i(w_addr), .cfg_wdata_i(w_wdata), .cfg_rdata_o(w_rdata)
  );

  function automatic logic [31:0] m_read(logic [7:0] a);
    for (int i = 0; i < N; i++) begin
      if (a == 8'(8'hD8 + 4 * i)) return m_ctl[i];
      if (a == 8'(8'hA0 + 8 * i)) return m_cnt[i][31:0];
      if (a == 8'(8'hA4 + 8 * i)) return {16'h0, m_cnt[i][47:32]};
    end
    return 32'h0;
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, compare read against model, then advance model
  task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input bit f, input logic [2:0] e, input string req);
    logic [31:0] exp;
    bit fz;
    @(negedge clk);
    wr = w; addr = a; wdata = d; freeze = f; ev = e;
    #2;
    exp = m_read(a);
    chk(rdata === exp, req, rdata, exp);
    @(posedge clk);
    fz = m_fen && (f || m_frz);
    for (int i = 0; i < N; i++) begin
      if (w && a == 8'hF4 && d[1]) m_cnt[i] = '0;
      else if (e[i] && m_ctl[i][0] && !fz) m_cnt[i] = m_cnt[i] + 1;
      if (w && a == 8'hF4 && d[0]) m_ctl[i] = '0;
      else if (w && a == 8'(8'hD8 + 4 * i)) m_ctl[i] = d;
    end
    if (w && a == 8'hF4) begin
      m_fen = d[16];
      m_frz = d[8];
    end
  endtask

  task automatic run_events(input int n, input bit f, input string req);
    for (int k = 0; k < n; k++) begin
      logic [2:0] e;
      logic [7:0] a;
      e = 3'((k * 5) ^ (k >> 1) ^ 3);
      a = (k % 2 == 0) ? 8'(8'hA0 + 8 * (k % 3)) : 8'(8'hA4 + 8 * (k % 3));
      cyc(1'b0, a, 32'h0, f, e, req);
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, 8'(8'hA0 + 8 * i), 32'h0, 1'b0, 3'b000, req);
      cyc(1'b0, 8'(8'hA4 + 8 * i), 32'h0, 1'b0, 3'b000, req);
      cyc(1'b0, 8'(8'hD8 + 4 * i), 32'h0, 1'b0, 3'b000, req);
    end
  endtask

  initial begin
    #800000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_ctl[i] = '0; end
    m_fen = 0; m_frz = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    read_all("R1");
    cyc(1'b0, 8'hF4, 32'h0, 1'b1, 3'b111, "R1");

    // R2 control words
    cyc(1'b1, 8'hD8, 32'h0000_0001, 1'b0, 3'b000, "R2");
    cyc(1'b1, 8'hDC, 32'hABCD_0001, 1'b0, 3'b000, "R2");
    cyc(1'b1, 8'hE0, 32'h5A5A_0000, 1'b0, 3'b111, "R2");
    read_all("R2");

    // R3 / R4 counting with counter 2 disabled
    run_events(25, 1'b0, "R3");
    cyc(1'b1, 8'hE0, 32'h0000_0003, 1'b0, 3'b111, "R3");
    run_events(30, 1'b0, "R4");

    // R6 freeze input ignored, then honoured
    run_events(10, 1'b1, "R6");
    cyc(1'b1, 8'hF4, 32'h0001_0000, 1'b1, 3'b111, "R6");
    run_events(10, 1'b1, "R6");
    run_events(6, 1'b0, "R6");

    // R7 manual freeze with and without enable
    cyc(1'b1, 8'hF4, 32'h0000_0100, 1'b0, 3'b111, "R7");
    run_events(8, 1'b0, "R7");
    cyc(1'b1, 8'hF4, 32'h0001_0100, 1'b0, 3'b111, "R7");
    run_events(8, 1'b0, "R7");
    // R5 box word reads zero after writes
    cyc(1'b0, 8'hF4, 32'h0, 1'b0, 3'b000, "R5");
    cyc(1'b1, 8'hF4, 32'h0000_0000, 1'b0, 3'b111, "R5");
    run_events(5, 1'b0, "R5");

    // R11 ignored writes and unmapped reads
    cyc(1'b1, 8'hA0, 32'hFFFF_FFFF, 1'b0, 3'b000, "R11");
    cyc(1'b1, 8'hA4, 32'hFFFF_FFFF, 1'b0, 3'b000, "R11");
    cyc(1'b1, 8'h50, 32'hFFFF_FFFF, 1'b0, 3'b000, "R11");
    cyc(1'b0, 8'h50, 32'h0, 1'b0, 3'b000, "R11");
    read_all("R11");

    // R8 counter clear beats same-cycle event
    cyc(1'b1, 8'hF4, 32'h0000_0002, 1'b0, 3'b111, "R8");
    read_all("R8");
    run_events(7, 1'b0, "R8");

    // R9 control clear, counters kept
    cyc(1'b1, 8'hF4, 32'h0000_0001, 1'b0, 3'b111, "R9");
    read_all("R9");
    run_events(6, 1'b0, "R9");

    // R10 wrap on a 12-bit instance
    @(negedge clk);
    w_wr = 1'b1; w_addr = 8'hD8; w_wdata = 32'h1;
    @(negedge clk);
    w_wr = 1'b0; w_ev = 3'b001; w_addr = 8'hA0;
    repeat (4095) @(negedge clk);
    w_ev = 3'b000;
    #2;
    chk(w_rdata === 32'h0000_0FFF, "R10 max", w_rdata, 32'h0000_0FFF);
    @(negedge clk);
    w_ev = 3'b001;
    @(negedge clk);
    w_ev = 3'b000;
    #2;
    chk(w_rdata === 32'h0, "R10 wrap", w_rdata, 32'h0);
    w_ev = 3'b001;
    repeat (3) @(negedge clk);
    w_ev = 3'b000;
    #2;
    chk(w_rdata === 32'h3, "R10 after wrap", w_rdata, 32'h3);
    w_addr = 8'hA4;
    #1;
    chk(w_rdata === 32'h0, "R4 narrow high word", w_rdata, 32'h0);

    report();
    $finish;
  end
endmodule